// File: doc/BRIEF.md
# Interrupt Message Address Composer

This block converts the routing word of one interrupt source into a message-signalled interrupt write aimed at a per-hart interrupt file. The write is a 64-bit address and a 32-bit data word. The routing word carries three values: a hart index, a guest index and an interrupt identity. A two-word address configuration describes how these values are laid into the page number of the destination. The low word holds the low 32 bits of the base page number. The high word holds the upper base bits, the widths of the guest, low-hart and group fields, the position of the group field, and a lock bit.

An upstream forwarding stage offers one routing word at a time on a valid/ready request port. Each accepted non-zero word becomes exactly one message on a valid/ready output port, held in a single output register. An all-zero routing word is accepted and then dropped, so it produces no message. Software-side configuration arrives through two write strobes that share one data bus. Setting the lock bit freezes both configuration words until reset.

Top module: `msi_target_composer`

## Requirements
- R1: After reset `msg_valid` is 0 and `req_ready` is 1.
- R2: `msg_data` equals routing-word bits 10:0 zero-extended to 32 bits; routing-word bit 11 has no effect.
- R3: The guest index (routing bits 17:12) is masked to G bits, where G is high-word bits 22:20, and occupies page-number bits G-1:0; with G=0 it does not appear.
- R4: The low hart bits (routing bits 31:18 masked to L bits, L = high-word bits 15:12) are placed at page-number bit G.
- R5: The group index, which is the hart index shifted right by L and masked to W bits (W = high-word bits 18:16), is placed at page-number bit S+12, where S is high-word bits 28:24.
- R6: The base page number is 44 bits, formed from high-word bits 11:0 above the 32-bit low word. Its bits that fall inside the guest, low-hart or group fields are cleared before it is ORed with them. Page-number bits above 43 are dropped, and the address equals the page number shifted left by 12.
- R7: A routing word of all zeros is accepted and yields no message.
- R8: While `msg_valid` is 1 and `msg_ready` is 0, the message holds stable and `req_ready` is 0. Each accepted non-zero word gives one message in the cycle after acceptance, in acceptance order.
- R9: A high-word write with bit 31 set takes effect and locks the configuration. Later writes to either word are then ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lo_we | input | 1 | Write strobe for the low configuration word |
| cfg_hi_we | input | 1 | Write strobe for the high configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Routing word offered |
| req_ready | output | 1 | Routing word accepted this cycle when valid |
| req_target | input | 32 | Routing word: hart 31:18, guest 17:12, identity 10:0 |
| msg_valid | output | 1 | Message write pending |
| msg_ready | input | 1 | Downstream takes the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
A corrupted configuration register stays invisible until the next non-zero routing word is accepted. It then shows as a wrong `msg_addr` in the following cycle. For that reason the address checks cover several width and shift settings, a base that overlaps every field, and a guest width of zero. A fault in the output register or its valid flag shows as a lost, duplicated or altered message under backpressure. The scoreboard catches such a fault on the first handshake after it. A lock that does not hold only shows up when a word is composed after the ignored writes.

// File: rtl/msi_comp_pkg.sv
package msi_comp_pkg;
  localparam int CFG_W      = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int BASE_HI_W  = 12;
  localparam int PPN_W      = CFG_W + BASE_HI_W;
  localparam int GRP_BIAS   = 12;

  localparam int HART_W  = 14;
  localparam int GUEST_W = 6;
  localparam int ID_W    = 11;
  localparam int HART_LSB  = 18;
  localparam int GUEST_LSB = 12;

  localparam int LOCK_BIT   = 31;
  localparam int GSHIFT_LSB = 24;
  localparam int GSHIFT_W   = 5;
  localparam int GUESTW_LSB = 20;
  localparam int GUESTW_W   = 3;
  localparam int GRPW_LSB   = 16;
  localparam int GRPW_W     = 3;
  localparam int HARTW_LSB  = 12;
  localparam int HARTW_W    = 4;

  typedef struct packed {
    logic [GSHIFT_W-1:0] grp_shift;
    logic [GUESTW_W-1:0] guest_w;
    logic [GRPW_W-1:0]   grp_w;
    logic [HARTW_W-1:0]  hart_w;
    logic [PPN_W-1:0]    base;
  } addr_cfg_t;
endpackage

// File: rtl/msi_rst_sync.sv
module msi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_comp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [CFG_W-1:0] wdata,
  output addr_cfg_t        cfg
);
  addr_cfg_t cfg_q, cfg_d;
  logic      lock_q, lock_d;
  logic      cfg_en;
  logic      unused_wbits;

  assign cfg_en       = !lock_q && (lo_we || hi_we);
  assign unused_wbits = ^{wdata[30:29], wdata[23], wdata[19]};

  always_comb begin
    cfg_d  = cfg_q;
    lock_d = lock_q;
    if (lo_we) cfg_d.base[CFG_W-1:0] = wdata;
    if (hi_we) begin
      cfg_d.base[PPN_W-1:CFG_W] = wdata[BASE_HI_W-1:0];
      cfg_d.hart_w    = wdata[HARTW_LSB +: HARTW_W];
      cfg_d.grp_w     = wdata[GRPW_LSB +: GRPW_W];
      cfg_d.guest_w   = wdata[GUESTW_LSB +: GUESTW_W];
      cfg_d.grp_shift = wdata[GSHIFT_LSB +: GSHIFT_W];
      lock_d          = wdata[LOCK_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      lock_q <= 1'b0;
    end else if (cfg_en) begin
      cfg_q  <= cfg_d;
      lock_q <= lock_d;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/msi_addr_calc.sv
module msi_addr_calc
  import msi_comp_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input  addr_cfg_t          cfg,
  input  logic [CFG_W-1:0]   target,
  output logic [ADDR_W-1:0]  addr,
  output logic [DATA_W-1:0]  data
);
  localparam int POS_W = $clog2(PPN_W) + 1;

  logic [PPN_W-1:0] ones;
  logic [PPN_W-1:0] hart_ext, guest_ext;
  logic [PPN_W-1:0] guest_mask, hart_low, hart_mask, grp_low, grp_mask;
  logic [PPN_W-1:0] guest_f, hart_f, grp_f, ppn;
  logic [POS_W-1:0] grp_pos;
  logic             unused_tbit;

  assign ones        = '1;
  assign hart_ext    = PPN_W'(target[HART_LSB +: HART_W]);
  assign guest_ext   = PPN_W'(target[GUEST_LSB +: GUEST_W]);
  assign unused_tbit = target[ID_W];

  always_comb begin
    grp_pos    = POS_W'(cfg.grp_shift) + POS_W'(GRP_BIAS);
    guest_mask = ~(ones << cfg.guest_w);
    hart_low   = ~(ones << cfg.hart_w);
    hart_mask  = hart_low << cfg.guest_w;
    grp_low    = ~(ones << cfg.grp_w);
    grp_mask   = grp_low << grp_pos;
    guest_f    = guest_ext & guest_mask;
    hart_f     = (hart_ext & hart_low) << cfg.guest_w;
    grp_f      = ((hart_ext >> cfg.hart_w) & grp_low) << grp_pos;
    ppn        = (cfg.base & ~(guest_mask | hart_mask | grp_mask))
               | guest_f | hart_f | grp_f;
  end

  assign addr = ADDR_W'({ppn, {PAGE_SHIFT{1'b0}}});
  assign data = DATA_W'(target[ID_W-1:0]);
endmodule

// File: rtl/msi_out_stage.sv
module msi_out_stage #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_fire,
  input  logic              in_load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              can_accept,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              pay_en;

  assign can_accept = !valid_q || out_ready;
  assign pay_en     = in_fire && in_load;

  always_comb begin
    valid_d = valid_q;
    if (in_fire)        valid_d = in_load;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (pay_en) begin
      addr_q <= in_addr;
      data_q <= in_data;
    end
  end

  assign out_valid = valid_q;
  assign out_addr  = addr_q;
  assign out_data  = data_q;
endmodule

// File: rtl/msi_target_composer.sv
module msi_target_composer
  import msi_comp_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lo_we,
  input  logic              cfg_hi_we,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_target,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [DATA_W-1:0] msg_data
);
  logic              rst_n_int;
  addr_cfg_t         cfg;
  logic [ADDR_W-1:0] calc_addr;
  logic [DATA_W-1:0] calc_data;
  logic              fire, nonzero;

  msi_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  msi_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n_int), .lo_we(cfg_lo_we), .hi_we(cfg_hi_we),
    .wdata(cfg_wdata), .cfg(cfg)
  );

  msi_addr_calc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_calc (
    .cfg(cfg), .target(req_target), .addr(calc_addr), .data(calc_data)
  );

  assign fire    = req_valid && req_ready;
  assign nonzero = |req_target;

  msi_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n_int), .in_fire(fire), .in_load(nonzero),
    .in_addr(calc_addr), .in_data(calc_data), .can_accept(req_ready),
    .out_ready(msg_ready), .out_valid(msg_valid), .out_addr(msg_addr),
    .out_data(msg_data)
  );
endmodule

// File: rtl/msi_target_composer_chk.sv
module msi_target_composer_chk #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [31:0]       req_target,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [ADDR_W-1:0] msg_addr,
  input logic [DATA_W-1:0] msg_data
);
  a_r1_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |-> req_ready);

  a_r2_data_width: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_data[DATA_W-1:11] == '0);

  a_r6_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[11:0] == '0 && msg_addr[ADDR_W-1:56] == '0));

  a_r7_zero_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_target == '0) |=> !msg_valid);

  a_r8_accept_emits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_target != '0) |=> msg_valid);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=>
      (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  a_r8_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |-> !req_ready);
endmodule

bind msi_target_composer msi_target_composer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_target(req_target), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/msi_target_composer_bench.sv
module msi_target_composer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_lo_we, cfg_hi_we;
  logic [31:0] cfg_wdata;
  logic        req_valid, req_ready;
  logic [31:0] req_target;
  logic        msg_valid, msg_ready;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  typedef struct {
    logic [63:0] addr;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          errors = 0;
  int          checks = 0;
  int          ready_mode = 0;
  int          cyc = 0;
  logic [31:0] m_lo = '0, m_hi = '0;
  bit          m_locked = 0;

  always #10 clk = ~clk;

  msi_target_composer u_msi_target_composer (
    .clk(clk), .rst_n(rst_n), .cfg_lo_we(cfg_lo_we), .cfg_hi_we(cfg_hi_we),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_target(req_target), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  function automatic logic [63:0] model_addr(input logic [31:0] lo,
                                             input logic [31:0] hi,
                                             input logic [31:0] t);
    longint unsigned s_grp, g_w, w_grp, l_w, base, hart, guest;
    longint unsigned gm, hm, grm, grp, ppn;
    s_grp = hi[28:24]; g_w = hi[22:20]; w_grp = hi[18:16]; l_w = hi[15:12];
    base  = {20'h0, hi[11:0], lo};
    hart  = t[31:18]; guest = t[17:12];
    gm  = (64'd1 << g_w) - 1;
    hm  = ((64'd1 << l_w) - 1) << g_w;
    grp = (hart >> l_w) & ((64'd1 << w_grp) - 1);
    grm = ((64'd1 << w_grp) - 1) << (s_grp + 12);
    ppn = (base & ~(gm | hm | grm)) | (guest & gm)
        | ((hart & ((64'd1 << l_w) - 1)) << g_w) | (grp << (s_grp + 12));
    ppn = ppn & ((64'd1 << 44) - 1);
    return ppn << 12;
  endfunction

  function automatic logic [31:0] mk(input int hart, input int guest, input int id);
    return {hart[13:0], guest[5:0], 1'b0, id[10:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input bit hi, input logic [31:0] v);
    @(posedge clk); #1;
    cfg_wdata = v;
    if (hi) cfg_hi_we = 1'b1; else cfg_lo_we = 1'b1;
    @(posedge clk); #1;
    cfg_hi_we = 1'b0; cfg_lo_we = 1'b0;
    if (!m_locked) begin
      if (hi) begin m_hi = v; m_locked = v[31]; end
      else m_lo = v;
    end
  endtask

  task automatic send(input logic [31:0] t, input string tag);
    exp_t e;
    @(posedge clk); #1;
    req_valid = 1'b1; req_target = t;
    do @(negedge clk); while (!req_ready);
    if (t != '0) begin
      e.addr = model_addr(m_lo, m_hi, t);
      e.data = {21'h0, t[10:0]};
      e.tag  = tag;
      q.push_back(e);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && q.size() != 0; i++) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && msg_valid && msg_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R7", "unexpected message addr", msg_addr, 64'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(msg_addr == e.addr, e.tag, "address", msg_addr, e.addr);
        check(msg_data == e.data, "R2", "data", {32'h0, msg_data}, {32'h0, e.data});
      end
    end
  end

  always @(posedge clk) begin
    #1;
    cyc++;
    case (ready_mode)
      0:       msg_ready = 1'b1;
      1:       msg_ready = (cyc % 3) != 1;
      default: msg_ready = 1'b0;
    endcase
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_lo_we = 0; cfg_hi_we = 0; cfg_wdata = '0;
    req_valid = 0; req_target = '0; msg_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(msg_valid == 1'b0, "R1", "msg_valid in reset", 64'(msg_valid), 64'h0);
    check(req_ready == 1'b1, "R1", "req_ready in reset", 64'(req_ready), 64'h1);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(msg_valid == 1'b0, "R1", "msg_valid after reset", 64'(msg_valid), 64'h0);

    // setting A: S=5, G=2, W=2, L=3, base hi 0x001
    cfg_write(1'b0, 32'h8000_0000);
    cfg_write(1'b1, (32'd5 << 24) | (32'd2 << 20) | (32'd2 << 16) | (32'd3 << 12) | 32'h001);
    send(mk(13, 3, 11'h7FF), "R4");
    send(mk(0, 6'h3F, 1), "R3");
    send(mk(14'h3FFF, 0, 5), "R5");
    send(mk(14'h18, 1, 11'h123), "R5");
    ready_mode = 1;
    for (int i = 0; i < 6; i++) send(mk(i * 977 + 3, i * 7, i * 101 + 1), "R8");
    drain();
    ready_mode = 0;

    // setting B: G=0, W=3, L=4, S=0, base overlapping every field
    cfg_write(1'b0, 32'hFFFF_FFFF);
    cfg_write(1'b1, (32'd3 << 16) | (32'd4 << 12) | 32'hABC);
    send(mk(14'h2A5, 6'h15, 2), "R6");
    send(mk(0, 6'h3F, 3), "R3");
    send(mk(14'h3FFF, 6'h3F, 4), "R6");
    drain();

    // setting C: widest fields, group pushed past page-number top
    cfg_write(1'b1, (32'd31 << 24) | (32'd7 << 20) | (32'd7 << 16) | (32'd15 << 12) | 32'h800);
    send(mk(14'h3FFF, 6'h2B, 6), "R6");
    drain();

    // zero routing word
    send(32'h0, "R7");
    repeat (3) begin
      @(negedge clk);
      check(msg_valid == 1'b0, "R7", "no message after zero word", 64'(msg_valid), 64'h0);
    end

    // identity only, bit 11 set
    send(mk(0, 0, 11'h400) | 32'h800, "R2");
    drain();

    // backpressure
    ready_mode = 2;
    @(posedge clk);
    send(mk(5, 1, 7), "R8");
    repeat (3) begin
      @(negedge clk);
      check(msg_valid == 1'b1, "R8", "held valid", 64'(msg_valid), 64'h1);
      check(req_ready == 1'b0, "R8", "ready low when full", 64'(req_ready), 64'h0);
      check(msg_addr == model_addr(m_lo, m_hi, mk(5, 1, 7)), "R8", "held address",
            msg_addr, model_addr(m_lo, m_hi, mk(5, 1, 7)));
    end
    ready_mode = 0;
    drain();

    // lock
    cfg_write(1'b0, 32'h1234_5000);
    cfg_write(1'b1, (32'd1 << 31) | (32'd7 << 24) | (32'd1 << 20) | (32'd1 << 16) | (32'd2 << 12) | 32'h005);
    cfg_write(1'b0, 32'h0);
    cfg_write(1'b1, 32'h0);
    send(mk(7, 1, 9), "R9");
    send(mk(14'h1F, 0, 10), "R9");
    drain();

    check(q.size() == 0, "R8", "all expected messages seen", 64'(q.size()), 64'h0);
    finish_run();
  end
endmodule